// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the request flags of many peripherals together with a small group of non-maskable trap inputs and presents one interrupt request to a processor. Alongside that request it reports the vector number of the winning source and the program-memory address of the table entry that holds the handler address for that vector. Every maskable source has an enable bit and a 3-bit user priority. Traps sit above all maskable sources and are never masked.

Arbitration has two stages. The highest user priority wins first, and among equals the source with the lowest vector number wins. The request goes out only when the winner's level is strictly above the processor's current priority level. A control bit moves every lookup from the primary vector table to an alternate table of the same layout that sits directly after it. Software sets up enables and priorities, sets or clears pending flags and changes the table select through a single-cycle write port. An acknowledge input clears the pending flag of the vector currently presented. Reset of the processor itself is outside this block.

Top module: `pvic_top`

## Requirements
- R1: A maskable request pulse on `src_req[i]` sets a sticky pending flag on the next clock edge. The registered outputs `irq`, `vec_num` and `vec_addr` change together on the edge after that, so a request seen at edge N shows at the outputs after edge N+1.
- R2: A maskable source whose enable bit is 0, or whose priority field is 0, never produces a request, even while its pending flag is set.
- R3: Any pending trap outranks every maskable source. It raises `irq` whatever the enable bits, the user priorities or `cpu_level` (even at level 7).
- R4: Trap t has vector number t (traps occupy slots 0 to 7). Maskable source i has vector number 8+i.
- R5: `irq` is 1 only when the winner's level is strictly greater than `cpu_level`. Traps count as level 8. When `irq` is 0, `vec_num` and `vec_addr` are 0.
- R6: With the alternate select clear, `vec_addr` = 0x000004 + 2 × `vec_num`.
- R7: A control write (`wr_op`=3) loads the alternate select from `wr_data[15]`. When that bit is set, `vec_addr` = 0x000100 + 2 × `vec_num`: the primary base plus 126 entries of two words each.
- R8: A higher user priority beats a lower vector number. Among sources of equal priority the lowest vector number wins, and among several traps the lowest trap wins.
- R9: `ack` at a clock edge while `irq` is 1 clears the pending flag of the vector presented at that edge. Other pending flags stay set. If a request on the same source arrives in that same cycle, the request wins.
- R10: A write with `wr_op`=1 sets, and a write with `wr_op`=2 clears, the pending flag of source `wr_idx`. Arbitration sees the change on the next cycle, so the outputs reflect it one edge after the write edge. Writes with `wr_idx` ≥ 21 are ignored.
- R11: A configuration write (`wr_op`=0) sets the enable of source `wr_idx` from `wr_data[3]` and its priority from `wr_data[2:0]`.
- R12: After reset, all pending flags, enables, priorities and the alternate select are 0, and `irq`, `vec_num` and `vec_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 21 | Maskable peripheral request pulses |
| trap_req | input | 4 | Non-maskable trap request pulses |
| cpu_level | input | 3 | Processor's current priority level |
| wr_en | input | 1 | Write strobe for the write port |
| wr_op | input | 2 | 0 config, 1 set pending, 2 clear pending, 3 control |
| wr_idx | input | 5 | Target maskable source index |
| wr_data | input | 16 | Write data (bit 3 enable, bits 2:0 priority, bit 15 alternate select) |
| ack | input | 1 | Acknowledge of the presented vector |
| irq | output | 1 | Interrupt request to the processor |
| vec_num | output | 7 | Winning vector number |
| vec_addr | output | 24 | Program address of the winning vector entry |

## Verification
The bench builds the block with its default values: 21 maskable sources, 4 active traps in 8 trap slots, 3-bit priorities and a 126-entry table starting at 0x000004. With these values the highest maskable vector (28) and both table bases can be reached, and the gap in vector numbers between the last trap and the first source is exercised. Seven priority levels across 21 sources make ties and priority inversions against vector order common under random stimulus, and every `cpu_level` from 0 to 7 is driven against them.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {
    OP_CFG  = 2'd0,
    OP_SETP = 2'd1,
    OP_CLRP = 2'd2,
    OP_CTRL = 2'd3
  } wr_op_e;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int NUM_SRC    = 21,
  parameter int NUM_TRAP   = 4,
  parameter int TRAP_SLOTS = 8,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 7,
  parameter int DATA_W     = 16,
  parameter int ALT_BIT    = 15,
  localparam int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_req,
  input  logic [NUM_TRAP-1:0]             trap_req,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_op,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            ack,
  input  logic                            ack_live,
  input  logic [VEC_W-1:0]                ack_vec,
  output logic [NUM_SRC-1:0]              src_pend,
  output logic [NUM_TRAP-1:0]             trap_pend,
  output logic [NUM_SRC-1:0]              src_en,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  src_prio,
  output logic                            alt_sel
);
  wr_op_e              op;
  logic                idx_ok;
  logic [NUM_SRC-1:0]  sel, sw_set, sw_clr, cfg_we, src_ack;
  logic [NUM_TRAP-1:0] trap_ack;
  logic [NUM_SRC-1:0]  src_pend_d;
  logic [NUM_TRAP-1:0] trap_pend_d;
  logic                ctrl_we;

  always_comb begin
    op      = wr_op_e'(wr_op);
    idx_ok  = int'(wr_idx) < NUM_SRC;
    ctrl_we = wr_en && (op == OP_CTRL);
    for (int i = 0; i < NUM_SRC; i++) begin
      sel[i]     = wr_en && idx_ok && (wr_idx == IDX_W'(i));
      sw_set[i]  = sel[i] && (op == OP_SETP);
      sw_clr[i]  = sel[i] && (op == OP_CLRP);
      cfg_we[i]  = sel[i] && (op == OP_CFG);
      src_ack[i] = ack && ack_live && (ack_vec == VEC_W'(TRAP_SLOTS + i));
    end
    for (int t = 0; t < NUM_TRAP; t++) begin
      trap_ack[t] = ack && ack_live && (ack_vec == VEC_W'(t));
    end
    // new requests take precedence over clears in the same cycle
    src_pend_d  = (src_pend & ~(src_ack | sw_clr)) | src_req | sw_set;
    trap_pend_d = (trap_pend & ~trap_ack) | trap_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pend  <= '0;
      trap_pend <= '0;
      alt_sel   <= 1'b0;
    end else begin
      src_pend  <= src_pend_d;
      trap_pend <= trap_pend_d;
      if (ctrl_we) alt_sel <= wr_data[ALT_BIT];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_en[g]   <= 1'b0;
        src_prio[g] <= '0;
      end else if (cfg_we[g]) begin
        src_en[g]   <= wr_data[PRIO_W];
        src_prio[g] <= wr_data[PRIO_W-1:0];
      end
    end
  end

  // R9: an acknowledged source with no fresh request is no longer pending
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack_chk
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ack[g] && !src_req[g] && !sw_set[g]) |=> !src_pend[g]);
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int NUM_SRC    = 21,
  parameter int NUM_TRAP   = 4,
  parameter int TRAP_SLOTS = 8,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 7,
  localparam int LVL_W     = PRIO_W + 1,
  localparam int NUM_CAND  = NUM_TRAP + NUM_SRC
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             src_pend,
  input  logic [NUM_TRAP-1:0]            trap_pend,
  input  logic [NUM_SRC-1:0]             src_en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
  output logic                           win_valid,
  output logic [VEC_W-1:0]               win_vec,
  output logic [LVL_W-1:0]               win_lvl
);
  localparam logic [LVL_W-1:0] TRAP_LVL = LVL_W'(1 << PRIO_W);

  logic [LVL_W-1:0] cand_lvl [NUM_CAND];
  logic [VEC_W-1:0] cand_vec [NUM_CAND];

  for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap
    assign cand_lvl[t] = trap_pend[t] ? TRAP_LVL : '0;
    assign cand_vec[t] = VEC_W'(t);
  end
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign cand_lvl[NUM_TRAP+s] = (src_pend[s] && src_en[s]) ? {1'b0, src_prio[s]} : '0;
    assign cand_vec[NUM_TRAP+s] = VEC_W'(TRAP_SLOTS + s);
  end

  // ascending scan with strict compare: ties keep the lower vector
  always_comb begin
    win_lvl = '0;
    win_vec = '0;
    for (int c = 0; c < NUM_CAND; c++) begin
      if (cand_lvl[c] > win_lvl) begin
        win_lvl = cand_lvl[c];
        win_vec = cand_vec[c];
      end
    end
    win_valid = (win_lvl != '0);
  end

  p_trap_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_pend) |-> (win_valid && (int'(win_vec) < NUM_TRAP)));
endmodule

// File: rtl/pvic_vecgen.sv
module pvic_vecgen #(
  parameter int NUM_SRC      = 21,
  parameter int NUM_TRAP     = 4,
  parameter int TRAP_SLOTS   = 8,
  parameter int PRIO_W       = 3,
  parameter int VEC_W        = 7,
  parameter int ADDR_W       = 24,
  parameter int TABLE_LEN    = 126,
  parameter int TABLE_BASE   = 4,
  parameter int ENTRY_STRIDE = 2,
  localparam int LVL_W       = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  logic [VEC_W-1:0]  win_vec,
  input  logic [LVL_W-1:0]  win_lvl,
  input  logic [PRIO_W-1:0] cpu_level,
  input  logic              alt_sel,
  output logic              irq,
  output logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam logic [ADDR_W-1:0] PRI_BASE = ADDR_W'(TABLE_BASE);
  localparam logic [ADDR_W-1:0] ALT_BASE = ADDR_W'(TABLE_BASE + TABLE_LEN * ENTRY_STRIDE);

  logic              fire;
  logic [ADDR_W-1:0] base, addr_d;
  logic [VEC_W-1:0]  vec_d;

  always_comb begin
    fire   = win_valid && (win_lvl > {1'b0, cpu_level});
    base   = alt_sel ? ALT_BASE : PRI_BASE;
    vec_d  = fire ? win_vec : '0;
    addr_d = fire ? (base + ADDR_W'(win_vec) * ADDR_W'(ENTRY_STRIDE)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
    end else begin
      irq      <= fire;
      vec_num  <= vec_d;
      vec_addr <= addr_d;
    end
  end

  p_level_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(win_lvl) > {1'b0, $past(cpu_level)}));
  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((int'(vec_num) < NUM_TRAP) ||
             ((int'(vec_num) >= TRAP_SLOTS) && (int'(vec_num) < TRAP_SLOTS + NUM_SRC))));
  p_addr_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec_addr[0] == 1'b0));
  p_alt_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((vec_addr >= ALT_BASE) == $past(alt_sel)));
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_num == '0 && vec_addr == '0));
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int NUM_SRC      = 21,
  parameter int NUM_TRAP     = 4,
  parameter int TRAP_SLOTS   = 8,
  parameter int PRIO_W       = 3,
  parameter int VEC_W        = 7,
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int ALT_BIT      = 15,
  parameter int TABLE_LEN    = 126,
  parameter int TABLE_BASE   = 4,
  parameter int ENTRY_STRIDE = 2,
  localparam int IDX_W       = $clog2(NUM_SRC),
  localparam int LVL_W       = PRIO_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_req,
  input  logic [NUM_TRAP-1:0] trap_req,
  input  logic [PRIO_W-1:0]   cpu_level,
  input  logic                wr_en,
  input  logic [1:0]          wr_op,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                ack,
  output logic                irq,
  output logic [VEC_W-1:0]    vec_num,
  output logic [ADDR_W-1:0]   vec_addr
);
  logic [NUM_SRC-1:0]             src_pend, src_en;
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
  logic [NUM_TRAP-1:0]            trap_pend;
  logic                           alt_sel;
  logic                           win_valid;
  logic [VEC_W-1:0]               win_vec;
  logic [LVL_W-1:0]               win_lvl;

  pvic_regs #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .TRAP_SLOTS(TRAP_SLOTS), .PRIO_W(PRIO_W),
    .VEC_W(VEC_W), .DATA_W(DATA_W), .ALT_BIT(ALT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
    .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data),
    .ack(ack), .ack_live(irq), .ack_vec(vec_num),
    .src_pend(src_pend), .trap_pend(trap_pend), .src_en(src_en),
    .src_prio(src_prio), .alt_sel(alt_sel)
  );

  pvic_arbiter #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .TRAP_SLOTS(TRAP_SLOTS),
    .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .trap_pend(trap_pend),
    .src_en(src_en), .src_prio(src_prio),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  pvic_vecgen #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .TRAP_SLOTS(TRAP_SLOTS), .PRIO_W(PRIO_W),
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .TABLE_LEN(TABLE_LEN), .TABLE_BASE(TABLE_BASE),
    .ENTRY_STRIDE(ENTRY_STRIDE)
  ) u_vec (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_vec(win_vec),
    .win_lvl(win_lvl), .cpu_level(cpu_level), .alt_sel(alt_sel),
    .irq(irq), .vec_num(vec_num), .vec_addr(vec_addr)
  );
endmodule

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  localparam int NS = 21;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic [NT-1:0] trap_req = '0;
  logic [2:0]    cpu_level = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_op = '0;
  logic [4:0]    wr_idx = '0;
  logic [15:0]   wr_data = '0;
  logic          ack = 1'b0;
  logic          irq;
  logic [6:0]    vec_num;
  logic [23:0]   vec_addr;

  int checks = 0;
  int errors = 0;

  bit m_src [NS];
  bit m_en  [NS];
  int m_prio[NS];
  bit m_trap[NT];
  bit m_alt;
  int m_lvl;

  pvic_top u_pvic_top (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
    .cpu_level(cpu_level), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
    .wr_data(wr_data), .ack(ack), .irq(irq), .vec_num(vec_num), .vec_addr(vec_addr)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void model(output bit e_irq, output int e_vec, output int e_addr);
    int best = 0;
    int v = 0;
    for (int t = 0; t < NT; t++)
      if (m_trap[t] && 8 > best) begin best = 8; v = t; end
    for (int i = 0; i < NS; i++)
      if (m_src[i] && m_en[i] && m_prio[i] > best) begin best = m_prio[i]; v = 8 + i; end
    e_irq  = best > m_lvl;
    e_vec  = e_irq ? v : 0;
    e_addr = e_irq ? ((m_alt ? 256 : 4) + 2 * v) : 0;
  endfunction

  task automatic check_raw(string req, bit e_irq, int e_vec, int e_addr);
    checks++;
    if (irq !== e_irq || int'(vec_num) != e_vec || int'(vec_addr) != e_addr) begin
      errors++;
      $display("FAIL %s: actual irq=%0b vec=%0d addr=%h expected irq=%0b vec=%0d addr=%h",
               req, irq, vec_num, vec_addr, e_irq, e_vec, e_addr);
    end
  endtask

  task automatic check_model(string req);
    bit ei; int ev; int ea;
    model(ei, ev, ea);
    check_raw(req, ei, ev, ea);
  endtask

  task automatic do_write(int op, int idx, int data);
    wr_en = 1'b1; wr_op = 2'(op); wr_idx = 5'(idx); wr_data = 16'(data);
    tick();
    wr_en = 1'b0;
    if (idx < NS) begin
      if (op == 0) begin m_en[idx] = data[3]; m_prio[idx] = data & 7; end
      if (op == 1) m_src[idx] = 1'b1;
      if (op == 2) m_src[idx] = 1'b0;
    end
    if (op == 3) m_alt = data[15];
    tick();
  endtask

  task automatic cfg(int idx, bit en, int prio);
    do_write(0, idx, (int'(en) << 3) | prio);
  endtask

  task automatic pulse_src(logic [NS-1:0] mask);
    src_req = mask;
    tick();
    src_req = '0;
    for (int i = 0; i < NS; i++) if (mask[i]) m_src[i] = 1'b1;
    tick();
  endtask

  task automatic pulse_trap(logic [NT-1:0] mask);
    trap_req = mask;
    tick();
    trap_req = '0;
    for (int t = 0; t < NT; t++) if (mask[t]) m_trap[t] = 1'b1;
    tick();
  endtask

  task automatic set_level(int l);
    cpu_level = 3'(l);
    m_lvl = l;
    tick();
    tick();
  endtask

  task automatic do_ack();
    bit ei; int ev; int ea;
    model(ei, ev, ea);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    if (ei) begin
      if (ev < 8) m_trap[ev] = 1'b0;
      else m_src[ev - 8] = 1'b0;
    end
    tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NS; i++) begin m_src[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
    for (int t = 0; t < NT; t++) m_trap[t] = 0;
    m_alt = 0; m_lvl = 0;
    tick(); tick();
    check_raw("R12 reset idle", 0, 0, 0);
    rst_n = 1'b1;
    tick();
    check_raw("R12 after release", 0, 0, 0);

    // R2: disabled / priority 0 never requests
    pulse_src(NS'(1) << 3);
    check_raw("R2 enable clear", 0, 0, 0);
    cfg(3, 1'b1, 0);
    check_raw("R2 priority zero", 0, 0, 0);
    cfg(3, 1'b1, 5);
    check_raw("R4 R6 R11 source 3 vector", 1, 11, 4 + 22);

    // R8: ties and priority over order
    cfg(7, 1'b1, 5);
    pulse_src(NS'(1) << 7);
    check_raw("R8 tie keeps lower vector", 1, 11, 26);
    cfg(9, 1'b1, 6);
    pulse_src(NS'(1) << 9);
    check_raw("R8 higher priority wins", 1, 17, 4 + 34);

    // R5: level gate
    set_level(6);
    check_raw("R5 equal level blocks", 0, 0, 0);
    set_level(5);
    check_raw("R5 level below passes", 1, 17, 38);
    set_level(7);
    check_raw("R5 level 7 blocks all maskable", 0, 0, 0);

    // R3: traps
    pulse_trap(4'b0100);
    check_raw("R3 trap beats level 7", 1, 2, 4 + 4);
    pulse_trap(4'b0010);
    check_raw("R8 lower trap wins", 1, 1, 6);

    // R9: acknowledge
    do_ack();
    check_raw("R9 ack trap 1", 1, 2, 8);
    do_ack();
    check_raw("R9 ack trap 2", 0, 0, 0);
    set_level(0);
    check_raw("R9 sources left pending", 1, 17, 38);

    // R7: alternate table
    do_write(3, 0, 16'h8000);
    check_raw("R7 alternate base", 1, 17, 256 + 34);
    do_write(3, 0, 16'h0000);
    check_raw("R7 back to primary", 1, 17, 38);

    // R10 with cycle timing (R1 style)
    cfg(20, 1'b1, 7);
    wr_en = 1'b1; wr_op = 2'd1; wr_idx = 5'd20; wr_data = '0;
    tick();
    wr_en = 1'b0;
    check_raw("R10 not yet visible", 1, 17, 38);
    tick();
    m_src[20] = 1'b1;
    check_raw("R10 set pending visible", 1, 28, 4 + 56);
    do_write(2, 20, 0);
    check_raw("R10 clear pending", 1, 17, 38);
    do_write(1, 25, 0);
    check_raw("R10 out of range index ignored", 1, 17, 38);

    // R1 timing for a hardware request
    cfg(0, 1'b1, 7);
    src_req = NS'(1);
    tick();
    src_req = '0;
    check_raw("R1 one edge later unchanged", 1, 17, 38);
    tick();
    m_src[0] = 1'b1;
    check_raw("R1 two edges later", 1, 8, 20);

    // R9: request in same cycle as ack wins
    src_req = NS'(1);
    ack = 1'b1;
    tick();
    src_req = '0; ack = 1'b0;
    tick();
    check_raw("R9 new request beats ack", 1, 8, 20);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: cfg($urandom_range(0, NS - 1), 1'($urandom_range(0, 3) != 0), $urandom_range(0, 7));
        2, 3: begin
          logic [NS-1:0] mk = '0;
          for (int k = 0; k < 2; k++) mk[$urandom_range(0, NS - 1)] = 1'b1;
          pulse_src(mk);
        end
        4: set_level($urandom_range(0, 7));
        5, 6: do_ack();
        7: do_write($urandom_range(1, 2), $urandom_range(0, 23), 0);
        8: do_write(3, 0, $urandom_range(0, 1) << 15);
        default: if ($urandom_range(0, 3) == 0) pulse_trap(NT'(1) << $urandom_range(0, NT - 1));
                 else set_level(0);
      endcase
      check_model("R8 R5 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule